// File: doc/BRIEF.md
# Run-Time Load-Store Conflict Table

This block lets a scheduler move a load above stores whose addresses are only known at run time. A speculative-load command reads memory like an ordinary load. It also records the load address against its destination register tag in a small associative table. Every later store compares its address with all live records in one cycle and flags each one it hits. When the original position of the load is reached, a verify command for the same destination register looks up the record. If the record is clean, the verify does nothing. If the record is flagged, the block issues the load again and raises a stall until memory returns the fresh data. A branch-style verify does not reload: it reports a taken flag that software uses to jump to compensation code.

Commands arrive on a valid/ready channel. `cmd_ready` is high only when the block is idle, so a command that needs memory applies back-pressure until its data is back. Read requests leave on a second valid/ready channel. The request holds its address stable until `mem_req_ready` is seen. Memory answers with `mem_rsp_valid` one or more cycles after the request handshake. The block always accepts that answer and holds one read outstanding at a time. Load results leave as a one-cycle pulse on `res_valid`, with no back-pressure.

Top module: `ldst_conflict_table`

## Requirements
- R1: After reset `cmd_ready` is 1, `mem_req_valid`, `stall`, `res_valid`, `vfy_clean` and `br_valid` are 0, and the table holds no records.
- R2: A speculative load (`cmd_op`=0) accepted at an edge raises `mem_req_valid` with `mem_req_addr`=`cmd_addr` after that edge, keeps `stall` at 0, and one cycle after the edge that samples `mem_rsp_valid` pulses `res_valid` with the command's tag and the returned data.
- R3: A verify (`cmd_op`=2) whose record is clean pulses `vfy_clean` for one cycle after acceptance and issues no memory request.
- R4: A verify whose record was hit by a store issues a read of `cmd_addr`, and holds `stall` at 1 from the cycle after acceptance until the cycle after the response edge. The reloaded data then appears on `res_valid`/`res_tag`/`res_data`.
- R5: A store (`cmd_op`=1) issues no memory request and does not flag a record whose address differs from the store address in any bit.
- R6: A branch-verify (`cmd_op`=3) pulses `br_valid` for one cycle after acceptance, with `br_taken`=1 exactly when the record is flagged or absent, and issues no memory request.
- R7: A verify or branch-verify removes the record it looked up, so a second verify of the same tag finds no record.
- R8: A verify or branch-verify that finds no record for its tag is treated as a conflict.
- R9: A speculative load to a tag that already has a record replaces it: the new address is logged and the conflict flag is cleared.
- R10: When all `ENTRIES` records are live and a new tag arrives, the record written longest ago is dropped, and its tag later verifies as a conflict. The others stay intact.
- R11: `cmd_ready` stays 0 while a read is requested or outstanding. `mem_req_valid` and `mem_req_addr` hold steady until the cycle after `mem_req_ready` is sampled high.
- R12: One store flags every live record whose address equals the store address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 speculative load, 1 store, 2 verify, 3 branch-verify |
| cmd_tag | input | TAG_W | Destination register tag |
| cmd_addr | input | ADDR_W | Word address of the load or store |
| mem_req_valid | output | 1 | Read request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Returned data |
| res_valid | output | 1 | Load result pulse |
| res_tag | output | TAG_W | Register tag of the result |
| res_data | output | DATA_W | Load result data |
| stall | output | 1 | Pipeline stall during a reissued load |
| vfy_clean | output | 1 | Verify completed with no conflict |
| br_valid | output | 1 | Branch-verify outcome valid |
| br_taken | output | 1 | Branch-verify saw a conflict |

## Verification
A stale or wrong record shows at the ports one cycle after the next verify of that tag. A lost conflict flag shows as a `vfy_clean` pulse where a read request with `stall` was due. A spurious flag or a wrong age order shows as an unexpected request or a wrong `br_taken`. A broken age order hides until the table fills, so the bench fills it and then verifies every tag. Sequencing faults show as a dropped or moved request address or an early `cmd_ready`. A wrong tag or data on the result shows in the cycle after the response.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic [1:0] {
    OP_SPEC   = 2'd0,
    OP_STORE  = 2'd1,
    OP_VERIFY = 2'd2,
    OP_BRVFY  = 2'd3
  } lct_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lct_state_e;
endpackage

// File: rtl/lct_pick.sv
// Chooses the slot a speculative load writes: its own tag's slot first,
// then the lowest free slot, then the slot holding the oldest record.
module lct_pick #(
  parameter int ENTRIES = 8,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] match,
  input  logic [ENTRIES-1:0] oldest,
  output logic [IW-1:0]      slot
);
  logic [IW-1:0] m_idx, f_idx, o_idx;
  logic          m_any, f_any;

  always_comb begin
    m_idx = '0;
    f_idx = '0;
    o_idx = '0;
    m_any = 1'b0;
    f_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        m_idx = IW'(i);
        m_any = 1'b1;
      end
      if (!vld[i]) begin
        f_idx = IW'(i);
        f_any = 1'b1;
      end
      if (oldest[i]) o_idx = IW'(i);
    end
    if (m_any)      slot = m_idx;
    else if (f_any) slot = f_idx;
    else            slot = o_idx;
  end
endmodule

// File: rtl/lct_table.sv
// Record storage: tag, address, conflict flag and age rank per slot.
// Live ranks always form 0..count-1; rank ENTRIES-1 marks the oldest when full.
module lct_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int ADDR_W  = 32,
  localparam int IW = $clog2(ENTRIES),
  localparam int AGW = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               look_hit,
  output logic               look_conf,
  input  logic               alloc_en,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  logic               inv_en,
  input  logic               st_en,
  input  logic [ADDR_W-1:0]  st_addr,
  output logic [ENTRIES-1:0] ent_valid
);
  logic [ENTRIES-1:0]  vld, conf, match, oldest;
  logic [TAG_W-1:0]    tag_q  [ENTRIES];
  logic [ADDR_W-1:0]   addr_q [ENTRIES];
  logic [AGW-1:0]      age_q  [ENTRIES];
  logic [IW-1:0]       wslot, hslot;
  logic [AGW-1:0]      wage, hage;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g]  = vld[g] && (tag_q[g] == look_tag);
      assign oldest[g] = vld[g] && (age_q[g] == AGW'(ENTRIES - 1));
    end
  endgenerate

  always_comb begin
    hslot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hslot = IW'(i);
  end

  assign look_hit  = |match;
  assign look_conf = |(match & conf);
  assign ent_valid = vld;
  assign hage      = age_q[hslot];
  assign wage      = vld[wslot] ? age_q[wslot] : AGW'(ENTRIES);

  lct_pick #(.ENTRIES(ENTRIES)) u_pick (
    .vld   (vld),
    .match (match),
    .oldest(oldest),
    .slot  (wslot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      conf <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        addr_q[i] <= '0;
        age_q[i]  <= '0;
      end
    end else if (alloc_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == wslot) begin
          vld[i]    <= 1'b1;
          conf[i]   <= 1'b0;
          tag_q[i]  <= look_tag;
          addr_q[i] <= alloc_addr;
          age_q[i]  <= '0;
        end else if (vld[i] && age_q[i] < wage) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end else if (inv_en && look_hit) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == hslot) vld[i] <= 1'b0;
        else if (vld[i] && age_q[i] > hage) age_q[i] <= age_q[i] - 1'b1;
      end
    end else if (st_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (vld[i] && addr_q[i] == st_addr) conf[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/lct_fsm.sv
// Command sequencing and the single outstanding memory read.
module lct_fsm
  import lct_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              look_hit,
  input  logic              look_conf,
  output logic              alloc_en,
  output logic              inv_en,
  output logic              st_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  output logic              stall,
  output logic              vfy_clean,
  output logic              br_valid,
  output logic              br_taken
);
  lct_state_e        state;
  lct_op_e           op;
  logic              acc, conflict, reiss;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;

  assign op        = lct_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign acc       = cmd_valid && cmd_ready;
  assign conflict  = !look_hit || look_conf;
  assign alloc_en  = acc && (op == OP_SPEC);
  assign st_en     = acc && (op == OP_STORE);
  assign inv_en    = acc && (op == OP_VERIFY || op == OP_BRVFY);

  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign stall         = reiss && (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      reiss     <= 1'b0;
      tag_q     <= '0;
      addr_q    <= '0;
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_data  <= '0;
      vfy_clean <= 1'b0;
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      vfy_clean <= 1'b0;
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acc) begin
            unique case (op)
              OP_SPEC: begin
                state  <= ST_REQ;
                reiss  <= 1'b0;
                tag_q  <= cmd_tag;
                addr_q <= cmd_addr;
              end
              OP_VERIFY: begin
                if (conflict) begin
                  state  <= ST_REQ;
                  reiss  <= 1'b1;
                  tag_q  <= cmd_tag;
                  addr_q <= cmd_addr;
                end else begin
                  vfy_clean <= 1'b1;
                end
              end
              OP_BRVFY: begin
                br_valid <= 1'b1;
                br_taken <= conflict;
              end
              default: ;
            endcase
          end
        end
        ST_REQ: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            state     <= ST_IDLE;
            reiss     <= 1'b0;
            res_valid <= 1'b1;
            res_tag   <= tag_q;
            res_data  <= mem_rsp_data;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldst_conflict_table.sv
module ldst_conflict_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  output logic              stall,
  output logic              vfy_clean,
  output logic              br_valid,
  output logic              br_taken
);
  logic               look_hit, look_conf, alloc_en, inv_en, st_en;
  logic [ENTRIES-1:0] ent_valid;

  lct_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_tag  (cmd_tag),
    .look_hit  (look_hit),
    .look_conf (look_conf),
    .alloc_en  (alloc_en),
    .alloc_addr(cmd_addr),
    .inv_en    (inv_en),
    .st_en     (st_en),
    .st_addr   (cmd_addr),
    .ent_valid (ent_valid)
  );

  lct_fsm #(
    .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (cmd_op),
    .cmd_tag      (cmd_tag),
    .cmd_addr     (cmd_addr),
    .look_hit     (look_hit),
    .look_conf    (look_conf),
    .alloc_en     (alloc_en),
    .inv_en       (inv_en),
    .st_en        (st_en),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .res_valid    (res_valid),
    .res_tag      (res_tag),
    .res_data     (res_data),
    .stall        (stall),
    .vfy_clean    (vfy_clean),
    .br_valid     (br_valid),
    .br_taken     (br_taken)
  );
endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               mem_rsp_valid,
  input logic               res_valid,
  input logic               stall,
  input logic               vfy_clean,
  input logic               br_valid,
  input logic [ENTRIES-1:0] ent_valid
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);
  // R4
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !cmd_ready);
  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vfy_clean, br_valid, res_valid}));
  // R2
  res_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rsp_valid));
  // R3
  clean_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_clean |-> !mem_req_valid && !stall);
  // R1
  empty_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> ent_valid == '0);
endmodule

bind ldst_conflict_table lct_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_ready    (cmd_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .res_valid    (res_valid),
  .stall        (stall),
  .vfy_clean    (vfy_clean),
  .br_valid     (br_valid),
  .ent_valid    (ent_valid)
);

// File: tb/ldst_conflict_table_test.sv
`timescale 1ns/1ps
module ldst_conflict_table_test;
  localparam int TAG_W = 6, ADDR_W = 32, DATA_W = 32, ENTRIES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [TAG_W-1:0] cmd_tag = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic mem_req_ready = 1'b0;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic cmd_ready, mem_req_valid, res_valid, stall, vfy_clean, br_valid, br_taken;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [TAG_W-1:0] res_tag;
  logic [DATA_W-1:0] res_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ldst_conflict_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  // kinds: 0 store, 1 speculative load, 2 clean verify, 3 reissued verify,
  //        4 branch not taken, 5 branch taken
  localparam int NV = 23;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 3'd1, 6'd1, 16'hA100},
    {2'd2, 3'd2, 6'd1, 16'hA100},
    {2'd2, 3'd3, 6'd1, 16'hA100},  // R7 record consumed
    {2'd0, 3'd1, 6'd2, 16'hA200},
    {2'd1, 3'd0, 6'd0, 16'hA200},
    {2'd2, 3'd3, 6'd2, 16'hA200},
    {2'd0, 3'd1, 6'd3, 16'hA300},
    {2'd1, 3'd0, 6'd0, 16'hA304},  // R5 other address
    {2'd3, 3'd4, 6'd3, 16'hA300},
    {2'd0, 3'd1, 6'd4, 16'hA400},
    {2'd1, 3'd0, 6'd0, 16'hA400},
    {2'd3, 3'd5, 6'd4, 16'hA400},
    {2'd3, 3'd5, 6'd9, 16'hA900},  // R8 no record, branch
    {2'd0, 3'd1, 6'd5, 16'hA500},
    {2'd1, 3'd0, 6'd0, 16'hA500},
    {2'd0, 3'd1, 6'd5, 16'hA508},  // R9 overwrite clears flag
    {2'd2, 3'd2, 6'd5, 16'hA508},
    {2'd0, 3'd1, 6'd6, 16'hA600},
    {2'd0, 3'd1, 6'd7, 16'hA600},
    {2'd1, 3'd0, 6'd0, 16'hA600},  // R12 both flagged
    {2'd2, 3'd3, 6'd6, 16'hA600},
    {2'd3, 3'd5, 6'd7, 16'hA600},
    {2'd2, 3'd3, 6'd9, 16'hA900}   // R8 no record, verify
  };

  function automatic logic [DATA_W-1:0] mdata(input logic [ADDR_W-1:0] a);
    return ~a ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_cmd(input int op, input int tag, input logic [ADDR_W-1:0] addr,
                        input int kind, input int lat, input string rq);
    @(negedge clk);
    chk(cmd_ready == 1'b1, rq, "ready before command", 32'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_tag   = TAG_W'(tag);
    cmd_addr  = addr;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    case (kind)
      0: chk(!mem_req_valid, rq, "store request", 32'(mem_req_valid), 0);
      2: chk(vfy_clean && !mem_req_valid && !stall, rq, "clean verify",
             {29'd0, vfy_clean, mem_req_valid, stall}, 32'h4);
      4, 5: chk(br_valid && br_taken == (kind == 5) && !mem_req_valid, rq, "branch",
                {30'd0, br_valid, br_taken}, {30'd0, 1'b1, kind == 5});
      default: begin
        chk(mem_req_valid && mem_req_addr == addr, rq, "request addr", mem_req_addr, addr);
        chk(stall == (kind == 3) && !cmd_ready, rq, "stall/ready",
            {30'd0, stall, cmd_ready}, {30'd0, kind == 3, 1'b0});
        for (int i = 0; i < lat; i++) begin
          @(posedge clk);
          @(negedge clk);
          // R11 request held under back-pressure
          chk(mem_req_valid && mem_req_addr == addr && !cmd_ready, "R11", "held request",
              mem_req_addr, addr);
        end
        mem_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mdata(addr);
        chk(!mem_req_valid && stall == (kind == 3), rq, "waiting",
            {30'd0, mem_req_valid, stall}, {30'd0, 1'b0, kind == 3});
        @(posedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(res_valid && res_tag == TAG_W'(tag) && res_data == mdata(addr), rq, "result",
            res_data, mdata(addr));
        chk(!stall && cmd_ready, rq, "released", {30'd0, stall, cmd_ready}, 32'h1);
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string rq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cmd_ready && !mem_req_valid && !stall && !res_valid && !vfy_clean && !br_valid,
        "R1", "reset outputs",
        {26'd0, cmd_ready, mem_req_valid, stall, res_valid, vfy_clean, br_valid}, 32'h20);

    for (int v = 0; v < NV; v++) begin
      case (int'(VEC[v][22:20]))
        0: rq = "R5";
        1: rq = "R2";
        2: rq = "R3";
        3: rq = "R4";
        default: rq = "R6";
      endcase
      do_cmd(int'(VEC[v][26:25]), int'(VEC[v][21:16] & 6'h3F) == 0 ? int'(VEC[v][21:16]) : int'(VEC[v][21:16]),
             {16'd0, VEC[v][15:0]}, int'(VEC[v][24:22]), 0, rq);
    end

    // R10 fill the table, then one more distinct tag evicts the oldest
    for (int t = 10; t < 10 + ENTRIES; t++) do_cmd(0, t, 32'hB000 + t, 1, 0, "R10");
    do_cmd(0, 10 + ENTRIES, 32'hB000 + 10 + ENTRIES, 1, 0, "R10");
    do_cmd(2, 10, 32'hB00A, 3, 0, "R10");
    for (int t = 11; t <= 10 + ENTRIES; t++) do_cmd(2, t, 32'hB000 + t, 2, 0, "R10");

    // R11 slow memory acceptance on both read kinds
    do_cmd(0, 20, 32'hC0_0014, 1, 3, "R11");
    do_cmd(2, 21, 32'hC0_0015, 3, 2, "R11");
    do_cmd(2, 20, 32'hC0_0014, 2, 0, "R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule